// File: doc/BRIEF.md
# Base-and-Bounds Address Relocator

This block sits between a processor's address generator and the memory address register. Each effective address that a program produces is turned into a physical address by adding a hidden relocation base. It is also compared with a region size, the bound. The base and the bound can be loaded only by privileged code, normally when the operating system switches tasks, and user code has no path to read them. The physical address leaves the block combinationally in the same cycle as the request, so the memory cycle can start at once. The bound comparison is registered and finishes one cycle later, while the bus cycle is running. When it fails, the block cancels the access: it raises a fault pulse, holds back the write strobe and reports the offending effective address.

A static strap input turns the whole unit off. With the strap low the physical address is the effective address and no fault is ever raised. The base width is a parameter. With a full-width base, any relocation in the 24-bit space is possible. A narrow base, for example 4 bits with a 16-bit address, is added only to the top bits of the address, which gives a small memory with programs placed on 4 KiB boundaries.

Top module: `reloc_unit`

## Requirements
- R1: After reset the base is 0, the bound equals 2^PA_W (the whole space) and the unit is enabled when the strap is high: pa equals ea, and no abort or write strobe is active.
- R2: While the strap is high, pa = ea + (base shifted left by PA_W-BASE_W), combinationally in the cycle in which ea is presented.
- R3: The sum is taken modulo 2^PA_W, so a relocated address past the top of the space wraps around to low addresses.
- R4: A configuration write (cfg_we high, cfg_sel 0 = base from the low BASE_W bits of cfg_wdata, cfg_sel 1 = bound from all PA_W+1 bits) takes effect only when priv is high. With priv low the write has no effect on translation or checking.
- R5: A configuration write in the same cycle as a translation takes effect from the next cycle on. The translation in that cycle uses the old values.
- R6: If ea_valid is high, the strap is high and ea >= bound, then abort is high for exactly the following cycle and abort_ea holds that ea. An ea below the bound raises no abort.
- R7: mem_we is high in the cycle after a valid request with ea_wr high, unless that request aborts. It is low in every other cycle.
- R8: With the strap low, pa equals ea whatever the base is, and no abort is raised whatever the bound is.
- R9: abort is never high in a cycle that does not follow a valid request.
- R10: With BASE_W=4 and PA_W=16, the base is added to the top nibble only, so base 0xA with ea 0x7123 gives pa 0x1123.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_strap | input | 1 | Static enable; low makes the unit transparent |
| priv | input | 1 | High when the processor is in privileged mode |
| cfg_we | input | 1 | Configuration write request |
| cfg_sel | input | 1 | 0 selects the base, 1 selects the bound |
| cfg_wdata | input | PA_W+1 | Configuration write data |
| ea_valid | input | 1 | Effective address is valid this cycle |
| ea_wr | input | 1 | The request is a write |
| ea | input | PA_W | Effective address |
| pa | output | PA_W | Physical address towards the memory address register |
| mem_we | output | 1 | Write strobe, one cycle after the request |
| abort | output | 1 | One-cycle fault pulse that cancels the access |
| abort_ea | output | PA_W | Effective address of the latest aborted access |

## Verification
The bench builds two instances. The first uses the default 24-bit address and a full-width base. With it, relocations that cross the top of the 16 MiB space, bounds of 0, 1 and the full size, and the equality boundary of the check all come within reach. The second uses a 16-bit address with a 4-bit base, so the nibble-only addition and its wrap inside 64 KiB are exercised against independently computed values.

// File: rtl/reloc_unit.sv
module reloc_unit #(
  parameter int PA_W   = 24,
  parameter int BASE_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_strap,
  input  logic            priv,
  input  logic            cfg_we,
  input  logic            cfg_sel,
  input  logic [PA_W:0]   cfg_wdata,
  input  logic            ea_valid,
  input  logic            ea_wr,
  input  logic [PA_W-1:0] ea,
  output logic [PA_W-1:0] pa,
  output logic            mem_we,
  output logic            abort,
  output logic [PA_W-1:0] abort_ea
);
  localparam int SHIFT = PA_W - BASE_W;
  localparam int BD_W  = PA_W + 1;
  localparam logic [BD_W-1:0] BOUND_MAX = BD_W'(1) << PA_W;

  logic [BASE_W-1:0] base_q;
  logic [BD_W-1:0]   bound_q;
  logic [PA_W-1:0]   offset;
  logic              over;

  assign offset = PA_W'(base_q) << SHIFT;
  assign pa     = en_strap ? ea + offset : ea;
  assign over   = en_strap && ea_valid && ({1'b0, ea} >= bound_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      bound_q  <= BOUND_MAX;
      abort    <= 1'b0;
      mem_we   <= 1'b0;
      abort_ea <= '0;
    end else begin
      if (cfg_we && priv) begin
        if (cfg_sel) bound_q <= cfg_wdata;
        else         base_q  <= cfg_wdata[BASE_W-1:0];
      end
      abort  <= over;
      mem_we <= ea_valid && ea_wr && !over;
      if (over) abort_ea <= ea;
    end
  end

  // R4
  cfg_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && priv) |=> ($stable(base_q) && $stable(bound_q)));

  // R6
  abort_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> $past(ea_valid && en_strap));

  // R7
  wstrobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(ea_valid && ea_wr));

  // R8
  strap_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!en_strap) |-> !abort);

  // R9
  abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !ea_valid) |=> !abort);
endmodule

// File: tb/reloc_unit_tb_top.sv
module reloc_unit_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, en_strap, priv, cfg_we, cfg_sel, ea_valid, ea_wr;
  logic [24:0] cfg_wdata;
  logic [23:0] ea, pa, abort_ea;
  logic mem_we, abort;

  logic s_cfg_we, s_cfg_sel, s_ea_valid;
  logic [16:0] s_cfg_wdata;
  logic [15:0] s_ea, s_pa, s_abort_ea;
  logic s_mem_we, s_abort;

  int total = 0;
  int bad = 0;
  bit done = 0;

  reloc_unit #(.PA_W(24), .BASE_W(24)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_strap(en_strap), .priv(priv),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ea_valid(ea_valid), .ea_wr(ea_wr), .ea(ea), .pa(pa),
    .mem_we(mem_we), .abort(abort), .abort_ea(abort_ea));

  reloc_unit #(.PA_W(16), .BASE_W(4)) dut_sm_i (
    .clk(clk), .rst_n(rst_n), .en_strap(1'b1), .priv(1'b1),
    .cfg_we(s_cfg_we), .cfg_sel(s_cfg_sel), .cfg_wdata(s_cfg_wdata),
    .ea_valid(s_ea_valid), .ea_wr(1'b0), .ea(s_ea), .pa(s_pa),
    .mem_we(s_mem_we), .abort(s_abort), .abort_ea(s_abort_ea));

  typedef struct packed {
    logic [23:0] base;
    logic [24:0] bound;
    logic [23:0] addr;
    logic        wr;
    logic [23:0] exp_pa;
    logic        exp_ab;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{24'h000000, 25'h1000000, 24'h000123, 1'b1, 24'h000123, 1'b0},
    '{24'h100000, 25'h0010000, 24'h00FFFF, 1'b1, 24'h10FFFF, 1'b0},
    '{24'h100000, 25'h0010000, 24'h010000, 1'b1, 24'h110000, 1'b1},
    '{24'hFFF000, 25'h0100000, 24'h002345, 1'b1, 24'h001345, 1'b0},
    '{24'h123456, 25'h0000001, 24'h000000, 1'b1, 24'h123456, 1'b0},
    '{24'h123456, 25'h0000000, 24'h000000, 1'b1, 24'h123456, 1'b1},
    '{24'h000010, 25'h0800000, 24'hFFFFFF, 1'b0, 24'h00000F, 1'b1},
    '{24'h7FFFFF, 25'h1000000, 24'h000001, 1'b0, 24'h800000, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic sel, input logic [24:0] d, input logic p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d; priv = p;
    @(negedge clk);
    cfg_we = 1'b0; priv = 1'b0;
  endtask

  task automatic access(input logic [23:0] a, input logic w, input logic [23:0] epa,
                        input logic eab, input string req);
    @(negedge clk);
    ea_valid = 1'b1; ea = a; ea_wr = w;
    #1;
    chk(pa == epa, req, 32'(pa), 32'(epa));
    @(negedge clk);
    ea_valid = 1'b0; ea_wr = 1'b0;
    #1;
    chk(abort == eab, req, 32'(abort), 32'(eab));
    chk(mem_we == (w && !eab), {req, " R7"}, 32'(mem_we), 32'(w && !eab));
    if (eab) chk(abort_ea == a, {req, " R6 ea"}, 32'(abort_ea), 32'(a));
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en_strap = 1'b1; priv = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0;
    cfg_wdata = '0; ea_valid = 1'b0; ea_wr = 1'b0; ea = '0;
    s_cfg_we = 1'b0; s_cfg_sel = 1'b0; s_cfg_wdata = '0; s_ea_valid = 1'b0; s_ea = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, whole space in bounds, no relocation
    #1;
    chk(abort == 1'b0 && mem_we == 1'b0, "R1 idle", {30'b0, abort, mem_we}, 32'h0);
    access(24'hFFFFFF, 1'b1, 24'hFFFFFF, 1'b0, "R1");

    // R2 R3 R6 R7: vector table
    foreach (VECS[i]) begin
      cfg(1'b0, {1'b0, VECS[i].base}, 1'b1);
      cfg(1'b1, VECS[i].bound, 1'b1);
      access(VECS[i].addr, VECS[i].wr, VECS[i].exp_pa, VECS[i].exp_ab,
             $sformatf("R2/R3/R6 vec%0d", i));
    end

    // R4: unprivileged writes ignored (base stays 7FFFFF, bound stays full)
    cfg(1'b0, 25'h0000042, 1'b0);
    cfg(1'b1, 25'h0000000, 1'b0);
    access(24'h000001, 1'b1, 24'h800000, 1'b0, "R4");

    // R5: same-cycle write uses old base, next cycle uses new
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 25'h0000100; priv = 1'b1;
    ea_valid = 1'b1; ea = 24'h000005; ea_wr = 1'b0;
    #1;
    chk(pa == 24'h800004, "R5 old", 32'(pa), 32'h800004);
    @(negedge clk);
    cfg_we = 1'b0; priv = 1'b0;
    #1;
    chk(pa == 24'h000105, "R5 new", 32'(pa), 32'h000105);
    @(negedge clk);
    ea_valid = 1'b0;

    // R8: strap low, out-of-bound address passes untranslated
    cfg(1'b1, 25'h0000010, 1'b1);
    en_strap = 1'b0;
    access(24'h000020, 1'b1, 24'h000020, 1'b0, "R8");
    en_strap = 1'b1;
    access(24'h000020, 1'b1, 24'h000120, 1'b1, "R6 strap back");

    // R9: no abort in the idle cycle after a pulse
    @(negedge clk);
    #1;
    chk(abort == 1'b0, "R9", 32'(abort), 32'h0);

    // R10: reduced variant, nibble base
    @(negedge clk);
    s_cfg_we = 1'b1; s_cfg_sel = 1'b0; s_cfg_wdata = 17'h0000A;
    @(negedge clk);
    s_cfg_we = 1'b0;
    s_ea_valid = 1'b1; s_ea = 16'h7123;
    #1;
    chk(s_pa == 16'h1123, "R10 wrap", 32'(s_pa), 32'h1123);
    @(negedge clk);
    s_ea = 16'h0FFF;
    #1;
    chk(s_pa == 16'hAFFF, "R10", 32'(s_pa), 32'hAFFF);
    @(negedge clk);
    s_ea_valid = 1'b0;
    #1;
    chk(s_abort == 1'b0, "R10 abort", 32'(s_abort), 32'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule